// File: doc/BRIEF.md
# Radius-Two Local Binary Pattern Extractor

This block converts a raster stream of grayscale pixels into a stream of 8-bit local binary patterns. Each pattern describes one pixel by comparing it with eight samples on a circle of radius two. The four axial samples are the pixels two rows or two columns away. Each of the four diagonal samples is the mean of two neighbouring off-axis pixels on that circle.

Pixels arrive in raster order under a valid/ready handshake. A start-of-frame marker flags the first pixel of a frame and an end-of-line marker flags the last pixel of each row, so line width and frame height come from the stream itself. Four line stores and a 5x5 window register supply each neighbourhood. A pattern is produced only for a centre pixel at least two rows and two columns away from every frame edge. Patterns leave in raster order under their own valid/ready handshake. When the output is stalled, the input is stalled as well, so no pixel is lost or repeated.

Top module: `lbp_r2_extractor`

## Requirements
- R1: In every pattern, bit 7 compares the pixel two rows above the centre, bit 5 the pixel two columns to the right, bit 3 the pixel two rows below and bit 1 the pixel two columns to the left.
- R2: The diagonal bits use the mean of two pixels. Rows and columns are counted down and to the right from the centre (r,c):
  - bit 6 uses (r-2,c+1) and (r-1,c+2);
  - bit 4 uses (r+1,c+2) and (r+2,c+1);
  - bit 2 uses (r+2,c-1) and (r+1,c-2);
  - bit 0 uses (r-1,c-2) and (r-2,c-1).
- R3: A bit is 1 when its sample is greater than or equal to the centre pixel. Diagonal means are compared without rounding, so a mean of x.5 against a centre of x+1 gives 0, and a mean equal to the centre gives 1.
- R4: A centre produces a pattern only when it lies at least two rows and two columns inside every frame edge. A W-by-H frame yields exactly (W-4)*(H-4) patterns in raster order, and none when W or H is below 5.
- R5: A pixel marked start-of-frame is taken as row 0, column 0, even when the previous frame was cut short. The pixel after an end-of-line pixel starts the next row at column 0.
- R6: While a pattern is offered and not taken, it stays offered and unchanged in the following cycle.
- R7: Whenever no pattern is offered, the input is ready.
- R8: While reset is asserted and in the cycle after it, no pattern is offered. After reset the input is ready.
- R9: The pattern for centre (r,c) is offered in the cycle right after the pixel at (r+2,c+2) is accepted. A pattern is never offered unless a pixel was accepted or the pattern was already waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A pixel is presented |
| in_ready | output | 1 | The block accepts the presented pixel |
| in_pixel | input | PIX_W | Grayscale pixel value |
| in_sof | input | 1 | Presented pixel is the first of a frame |
| in_eol | input | 1 | Presented pixel is the last of its row |
| out_valid | output | 1 | A pattern is offered |
| out_ready | input | 1 | Downstream takes the offered pattern |
| out_pattern | output | 8 | Binary pattern, bit 7 north, then clockwise |

## Verification
The bench builds the block with MAX_COLS and MAX_ROWS both set to 16, which keeps frames small. At that size a full-width frame drives the line stores to their last address. At the same size it is cheap to mix frames that are too narrow, too short, a single interior pixel or cut short before the next start-of-frame. Values limited to a few grey levels, together with a handcrafted neighbourhood, make the sample-equals-centre and half-value cases common. Random stalls on both sides cover the hold and no-loss behaviour.

// File: rtl/lbp_r2_pkg.sv
package lbp_r2_pkg;

   localparam int RAD    = 2;
   localparam int WIN    = 2 * RAD + 1;
   localparam int NDIR   = 8;
   localparam int NLINES = WIN - 1;

   typedef enum logic [2:0] {
      DIR_N, DIR_NE, DIR_E, DIR_SE, DIR_S, DIR_SW, DIR_W, DIR_NW
   } lbp_dir_e;

   // Window row (0 = oldest line) of tap 'which' for a direction.
   function automatic int tap_row(input int dir, input int which);
      case (dir)
         0:       return 0;
         1:       return (which == 0) ? 0 : 1;
         2:       return RAD;
         3:       return (which == 0) ? 3 : 4;
         4:       return WIN - 1;
         5:       return (which == 0) ? 4 : 3;
         6:       return RAD;
         default: return (which == 0) ? 1 : 0;
      endcase
   endfunction

   // Window column (0 = oldest column) of tap 'which' for a direction.
   function automatic int tap_col(input int dir, input int which);
      case (dir)
         0:       return RAD;
         1:       return (which == 0) ? 3 : 4;
         2:       return WIN - 1;
         3:       return (which == 0) ? 4 : 3;
         4:       return RAD;
         5:       return (which == 0) ? 1 : 0;
         6:       return 0;
         default: return (which == 0) ? 0 : 1;
      endcase
   endfunction

endpackage

// File: rtl/lbp_r2_raster_pos.sv
module lbp_r2_raster_pos
   import lbp_r2_pkg::*;
#(
   parameter int MAX_COLS = 130,
   parameter int MAX_ROWS = 150,
   localparam int COL_W   = $clog2(MAX_COLS),
   localparam int ROW_W   = $clog2(MAX_ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             sof,
   input  logic             eol,
   output logic [COL_W-1:0] cur_col,
   output logic [ROW_W-1:0] cur_row,
   output logic             inner
);

   logic [COL_W-1:0] col_q;
   logic [ROW_W-1:0] row_q;

   assign cur_col = sof ? '0 : col_q;
   assign cur_row = sof ? '0 : row_q;

   // window completes an interior centre once 2*RAD rows and columns precede it
   assign inner = (cur_col >= COL_W'(2 * RAD)) && (cur_row >= ROW_W'(2 * RAD));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
      end else if (step) begin
         if (eol) begin
            col_q <= '0;
            row_q <= (cur_row != ROW_W'(MAX_ROWS - 1)) ? cur_row + ROW_W'(1) : cur_row;
         end else begin
            col_q <= (cur_col != COL_W'(MAX_COLS - 1)) ? cur_col + COL_W'(1) : cur_col;
            row_q <= cur_row;
         end
      end
   end

endmodule

// File: rtl/lbp_r2_line_store.sv
module lbp_r2_line_store
   import lbp_r2_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int MAX_COLS = 130,
   localparam int COL_W   = $clog2(MAX_COLS)
) (
   input  logic                         clk,
   input  logic                         wr_en,
   input  logic [COL_W-1:0]             addr,
   input  logic [PIX_W-1:0]             din,
   output logic [WIN-1:0][PIX_W-1:0]    column
);

   // chain[0] is the incoming pixel, chain[k+1] the same column k+1 lines ago
   logic [NLINES:0][PIX_W-1:0] chain;

   assign chain[0] = din;

   for (genvar k = 0; k < NLINES; k++) begin : g_line
      logic [PIX_W-1:0] mem [MAX_COLS];

      assign chain[k + 1] = mem[addr];

      always_ff @(posedge clk) begin
         if (wr_en) mem[addr] <= chain[k];
      end
   end

   // column[0] is the oldest line, column[WIN-1] the current pixel
   for (genvar j = 0; j < WIN; j++) begin : g_tap
      assign column[WIN - 1 - j] = chain[j];
   end

endmodule

// File: rtl/lbp_r2_window.sv
module lbp_r2_window
   import lbp_r2_pkg::*;
#(
   parameter int PIX_W = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                shift,
   input  logic [WIN-1:0][PIX_W-1:0]           column,
   output logic [WIN-1:0][WIN-1:0][PIX_W-1:0]  win
);

   for (genvar r = 0; r < WIN; r++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            win[r] <= '0;
         end else if (shift) begin
            win[r] <= {column[r], win[r][WIN-1:1]};
         end
      end
   end

endmodule

// File: rtl/lbp_r2_code.sv
module lbp_r2_code
   import lbp_r2_pkg::*;
#(
   parameter int PIX_W = 8
) (
   input  logic [WIN-1:0][WIN-1:0][PIX_W-1:0]  win,
   output logic [NDIR-1:0]                     pattern
);

   logic [PIX_W:0] centre_x2;
   logic           unused_taps;

   assign centre_x2   = {win[RAD][RAD], 1'b0};
   assign unused_taps = ^win;

   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      localparam int AR = tap_row(d, 0);
      localparam int AC = tap_col(d, 0);
      localparam int BR = tap_row(d, 1);
      localparam int BC = tap_col(d, 1);

      logic [PIX_W:0] pair_sum;

      // axial directions name one tap twice: sum equals twice the sample
      assign pair_sum = {1'b0, win[AR][AC]} + {1'b0, win[BR][BC]};
      assign pattern[NDIR - 1 - d] = (pair_sum >= centre_x2);
   end

endmodule

// File: rtl/lbp_r2_extractor.sv
module lbp_r2_extractor
   import lbp_r2_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int MAX_COLS = 130,
   parameter int MAX_ROWS = 150
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [PIX_W-1:0] in_pixel,
   input  logic             in_sof,
   input  logic             in_eol,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [7:0]       out_pattern
);

   localparam int COL_W = $clog2(MAX_COLS);
   localparam int ROW_W = $clog2(MAX_ROWS);

   if (PIX_W < 1) begin : g_bad_pix
      $error("lbp_r2_extractor: PIX_W must be at least 1");
   end
   if (MAX_COLS < WIN) begin : g_bad_cols
      $error("lbp_r2_extractor: MAX_COLS must cover the window width");
   end
   if (MAX_ROWS < WIN) begin : g_bad_rows
      $error("lbp_r2_extractor: MAX_ROWS must cover the window height");
   end

   logic                               take;
   logic                               hold_q;
   logic                               inner;
   logic [COL_W-1:0]                   cur_col;
   logic [ROW_W-1:0]                   cur_row;
   logic [WIN-1:0][PIX_W-1:0]          column;
   logic [WIN-1:0][WIN-1:0][PIX_W-1:0] win;
   logic [NDIR-1:0]                    pattern;
   logic                               unused_row;

   assign in_ready   = !hold_q || out_ready;
   assign take       = in_valid && in_ready;
   assign unused_row = ^cur_row;

   lbp_r2_raster_pos #(
      .MAX_COLS (MAX_COLS),
      .MAX_ROWS (MAX_ROWS)
   ) u_pos (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (take),
      .sof     (in_sof),
      .eol     (in_eol),
      .cur_col (cur_col),
      .cur_row (cur_row),
      .inner   (inner)
   );

   lbp_r2_line_store #(
      .PIX_W    (PIX_W),
      .MAX_COLS (MAX_COLS)
   ) u_lines (
      .clk    (clk),
      .wr_en  (take),
      .addr   (cur_col),
      .din    (in_pixel),
      .column (column)
   );

   lbp_r2_window #(
      .PIX_W (PIX_W)
   ) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .shift  (take),
      .column (column),
      .win    (win)
   );

   lbp_r2_code #(
      .PIX_W (PIX_W)
   ) u_code (
      .win     (win),
      .pattern (pattern)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
      end else if (take) begin
         hold_q <= inner;
      end else if (out_ready) begin
         hold_q <= 1'b0;
      end
   end

   assign out_valid   = hold_q;
   assign out_pattern = pattern;

endmodule

// File: rtl/lbp_r2_checker.sv
module lbp_r2_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_ready,
   input logic       in_sof,
   input logic       in_eol,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_pattern
);

   logic       acc;
   logic [2:0] cc, cr, pc, pr;
   logic       deep;

   assign acc  = in_valid && in_ready;
   assign pc   = in_sof ? 3'd0 : cc;
   assign pr   = in_sof ? 3'd0 : cr;
   assign deep = (pc >= 3'd4) && (pr >= 3'd4);

   // position tracked from the stream markers, saturating at four
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cc <= 3'd0;
         cr <= 3'd0;
      end else if (acc) begin
         if (in_eol) begin
            cc <= 3'd0;
            cr <= (pr < 3'd4) ? pr + 3'd1 : pr;
         end else begin
            cc <= (pc < 3'd4) ? pc + 3'd1 : pc;
            cr <= pr;
         end
      end
   end

   p_reset_idle_r8: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_pattern));

   p_ready_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   p_border_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !deep |=> !out_valid);

   p_fill_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc && deep |=> out_valid);

   p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(acc));

endmodule

bind lbp_r2_extractor lbp_r2_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .in_sof      (in_sof),
   .in_eol      (in_eol),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_pattern (out_pattern)
);

// File: tb/lbp_r2_extractor_bench.sv
module lbp_r2_extractor_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NCOLS      = 16;
   localparam int NROWS      = 16;
   localparam int WDOG       = 60000;
   localparam int DEPTH      = 4096;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_pixel = '0;
   logic       in_sof = 1'b0;
   logic       in_eol = 1'b0;
   logic       out_valid;
   logic       out_ready = 1'b0;
   logic [7:0] out_pattern;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lbp_r2_extractor #(
      .PIX_W    (8),
      .MAX_COLS (NCOLS),
      .MAX_ROWS (NROWS)
   ) u_lbp_r2_extractor (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .in_pixel    (in_pixel),
      .in_sof      (in_sof),
      .in_eol      (in_eol),
      .out_valid   (out_valid),
      .out_ready   (out_ready),
      .out_pattern (out_pattern)
   );

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0] stim_pix [DEPTH];
   bit         stim_sof [DEPTH];
   bit         stim_eol [DEPTH];
   bit         stim_int [DEPTH];
   int         n_stim = 0;
   logic [7:0] exp_pat [DEPTH];
   int         n_exp = 0;
   int         fr [NROWS][NCOLS];

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic bit ge_pair(int r, int c, int ra, int ca, int rb, int cb);
      return (fr[r + ra][c + ca] + fr[r + rb][c + cb]) >= 2 * fr[r][c];
   endfunction

   // reference pattern for centre (r,c), rows counted downward
   function automatic logic [7:0] ref_pat(int r, int c);
      logic [7:0] p;
      p[7] = ge_pair(r, c, -2,  0, -2,  0);
      p[6] = ge_pair(r, c, -2,  1, -1,  2);
      p[5] = ge_pair(r, c,  0,  2,  0,  2);
      p[4] = ge_pair(r, c,  1,  2,  2,  1);
      p[3] = ge_pair(r, c,  2,  0,  2,  0);
      p[2] = ge_pair(r, c,  2, -1,  1, -2);
      p[1] = ge_pair(r, c,  0, -2,  0, -2);
      p[0] = ge_pair(r, c, -1, -2, -2, -1);
      return p;
   endfunction

   // mode 0 flat, 1 random, 2 few levels, 3 handcrafted, 4 gradient; cut>0 stops early
   task automatic add_frame(int w, int h, int mode, int cut);
      int total;
      for (int r = 0; r < h; r++) begin
         for (int c = 0; c < w; c++) begin
            case (mode)
               0:       fr[r][c] = 77;
               1:       fr[r][c] = int'($urandom % 256);
               2:       fr[r][c] = int'($urandom % 4);
               4:       fr[r][c] = (c * 20 + r * 7) % 256;
               default: fr[r][c] = 0;
            endcase
         end
      end
      if (mode == 3) begin
         fr[2][2] = 101;
         fr[0][3] = 100; fr[1][4] = 101;
         fr[3][4] = 101; fr[4][3] = 101;
         fr[0][2] = 101; fr[2][4] = 100;
         fr[4][2] = 255; fr[2][0] = 0;
         fr[4][1] = 102; fr[3][0] = 100;
         fr[1][0] = 200; fr[0][1] = 1;
      end
      total = (cut > 0) ? cut : w * h;
      for (int i = 0; i < total; i++) begin
         int r;
         int c;
         r = i / w;
         c = i % w;
         stim_pix[n_stim] = 8'(fr[r][c]);
         stim_sof[n_stim] = (i == 0);
         stim_eol[n_stim] = (c == w - 1);
         stim_int[n_stim] = (r >= 4) && (c >= 4);
         if (stim_int[n_stim]) begin
            exp_pat[n_exp] = ref_pat(r - 2, c - 2);
            n_exp++;
         end
         n_stim++;
      end
   endtask

   initial begin
      int  si;
      int  ei;
      int  cyc;
      int  pct;
      bit  acc;
      bit  rdy;
      bit  stalled;
      logic [7:0] held;

      void'($urandom(32'd7321));

      add_frame(5, 5, 0, 0);     // single centre, all equal
      add_frame(5, 5, 3, 0);     // half-value and equality taps
      add_frame(16, 16, 1, 0);   // full width and height
      add_frame(10, 4, 1, 34);   // cut short, then restart
      add_frame(9, 7, 2, 0);
      add_frame(4, 8, 1, 0);     // too narrow
      add_frame(8, 4, 1, 0);     // too short
      add_frame(12, 9, 4, 0);
      add_frame(7, 6, 1, 0);
      add_frame(13, 10, 2, 0);

      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
      check(in_ready == 1'b1, "R8 in_ready after reset", int'(in_ready), 1);

      si = 0; ei = 0; cyc = 0; acc = 1'b0; stalled = 1'b0; held = '0;
      while ((si < n_stim || ei < n_exp) && cyc < WDOG) begin
         @(negedge clk);
         cyc++;
         if (acc) begin
            if (stim_int[si])
               check(out_valid == 1'b1, "R9 pattern after completing pixel", int'(out_valid), 1);
            si++;
         end
         if (stalled)
            check(out_valid && (out_pattern == held), "R6 stalled pattern held",
                  int'(out_pattern), int'(held));
         case ((cyc / 300) % 3)
            0:       pct = 90;
            1:       pct = 45;
            default: pct = 15;
         endcase
         rdy = (($urandom % 100) < pct);
         out_ready = rdy;
         if (out_valid && rdy) begin
            if (ei < n_exp)
               check(out_pattern == exp_pat[ei], "R1/R2/R3/R5 pattern value",
                     int'(out_pattern), int'(exp_pat[ei]));
            else
               check(1'b0, "R4 extra pattern", int'(out_pattern), 0);
            ei++;
         end
         stalled = out_valid && !rdy;
         held    = out_pattern;
         if (si < n_stim && (($urandom % 100) < 70)) begin
            in_valid = 1'b1;
            in_pixel = stim_pix[si];
            in_sof   = stim_sof[si];
            in_eol   = stim_eol[si];
         end else begin
            in_valid = 1'b0;
            in_pixel = 8'($urandom);
            in_sof   = 1'($urandom);
            in_eol   = 1'($urandom);
         end
         #1;
         if (!out_valid)
            check(in_ready == 1'b1, "R7 ready when nothing offered", int'(in_ready), 1);
         acc = in_valid && in_ready;
      end

      if (cyc >= WDOG) check(1'b0, "watchdog expired", cyc, WDOG);

      in_valid  = 1'b0;
      out_ready = 1'b1;
      repeat (20) begin
         @(negedge clk);
         check(out_valid == 1'b0, "R4 no pattern beyond interior", int'(out_valid), 0);
      end
      check(ei == n_exp, "R4 pattern count", ei, n_exp);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule